// File: doc/BRIEF.md
# Windowed Pixel Write Address Generator

This block turns a stream of register selects and data words, in the manner of a command/data display controller, into frame-buffer writes of 16-bit RGB565 pixels. A register select is latched and applies to every data word that follows it. Four select codes load the bounds of a rectangular drawing window. Any other select makes each data word a pixel.

A pixel is written at the current cursor. The cursor then moves to the right. Past the right bound it returns to the left bound on the next row, and past the bottom bound it returns to the top-left corner of the window. Each pixel becomes one memory write strobe, carrying the linear address `FB_WIDTH * y + x` and the pixel word.

The address comes from a registered multiply-add, so the write appears one cycle after the pixel is accepted. The data input uses a valid/ready handshake, and it stalls for the cycle in which that write is presented.

Top module: `pixwin_writer`

## Requirements
- R1: After reset, `mem_we` is 0, `din_ready` is 1, the cursor and all four bounds are 0, and the latched select is 0, so the first data words are pixels written at address 0.
- R2: A data word accepted while the latched select is 0x01 loads the left bound and the cursor column with its low `COORD_W` bits, and it produces no memory write.
- R3: A data word accepted under select 0x02 loads the right bound and produces no memory write.
- R4: A data word accepted under select 0x03 loads the top bound and the cursor row, and it produces no memory write.
- R5: A data word accepted under select 0x04 loads the bottom bound and produces no memory write.
- R6: A data word accepted under any other select causes, in the next cycle only, `mem_we`=1, `mem_addr`=`FB_WIDTH*y+x` at the cursor held when the word was accepted, and `mem_wdata` equal to the word.
- R7: After each pixel, the column increments. If the column was already at or beyond the right bound, it reloads the left bound instead and the row increments.
- R8: When the column wraps and the row was already at or beyond the bottom bound, the row reloads the top bound, so writes resume at the window's top-left corner.
- R9: `din_ready` is 0 exactly in the cycles in which `mem_we` is 1. A word offered then is held off until the next cycle.
- R10: A select presented with `sel_valid` takes effect for data accepted in later cycles. A data word accepted in the same cycle uses the previously latched select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_valid | input | 1 | Load a new register select |
| sel_code | input | 8 | Register select value |
| din_valid | input | 1 | Data word offered |
| din_ready | output | 1 | Data word can be taken this cycle |
| din_data | input | PIX_W | Data word: bound value or RGB565 pixel |
| mem_we | output | 1 | Frame-buffer write strobe |
| mem_addr | output | ADDR_W | Linear pixel address |
| mem_wdata | output | PIX_W | Pixel written |

## Verification
The bench builds the block with `FB_WIDTH`=16, `COORD_W`=6 and `ADDR_W`=11. With these values every address is small enough to be worked out by hand, and a 2048-entry reference memory covers the whole address space. A 3×2 window placed away from the origin shows the column wrap and the row wrap as distinct address jumps (20→34 and 36→18). A run of eight pixels wraps the window once more than it holds. A select change given in the same cycle as a data word exercises the ordering of select and data.

// File: rtl/pixwin_pkg.sv
package pixwin_pkg;

  localparam int SEL_W = 8;

  localparam logic [SEL_W-1:0] SEL_LEFT   = 8'h01;
  localparam logic [SEL_W-1:0] SEL_RIGHT  = 8'h02;
  localparam logic [SEL_W-1:0] SEL_TOP    = 8'h03;
  localparam logic [SEL_W-1:0] SEL_BOTTOM = 8'h04;

  typedef enum logic [2:0] {
    OP_PIXEL,
    OP_LEFT,
    OP_RIGHT,
    OP_TOP,
    OP_BOTTOM
  } win_op_e;

  function automatic win_op_e decode_sel(input logic [SEL_W-1:0] code);
    case (code)
      SEL_LEFT:   return OP_LEFT;
      SEL_RIGHT:  return OP_RIGHT;
      SEL_TOP:    return OP_TOP;
      SEL_BOTTOM: return OP_BOTTOM;
      default:    return OP_PIXEL;
    endcase
  endfunction

endpackage

// File: rtl/pixwin_cursor.sv
module pixwin_cursor
  import pixwin_pkg::*;
#(
  parameter int COORD_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               accept,
  input  win_op_e            op,
  input  logic [COORD_W-1:0] val,
  output logic [COORD_W-1:0] cur_x,
  output logic [COORD_W-1:0] cur_y
);

  logic [COORD_W-1:0] left_q, right_q, top_q, bottom_q, x_q, y_q;
  logic [COORD_W-1:0] left_d, right_d, top_d, bottom_d, x_d, y_d;
  logic               col_end, row_end;

  assign col_end = (x_q >= right_q);
  assign row_end = (y_q >= bottom_q);

  always_comb begin
    left_d   = left_q;
    right_d  = right_q;
    top_d    = top_q;
    bottom_d = bottom_q;
    x_d      = x_q;
    y_d      = y_q;
    if (accept) begin
      case (op)
        OP_LEFT: begin
          left_d = val;
          x_d    = val;
        end
        OP_RIGHT:  right_d = val;
        OP_TOP: begin
          top_d = val;
          y_d   = val;
        end
        OP_BOTTOM: bottom_d = val;
        default: begin
          if (col_end) begin
            x_d = left_q;
            y_d = row_end ? top_q : y_q + 1'b1;
          end else begin
            x_d = x_q + 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q   <= '0;
      right_q  <= '0;
      top_q    <= '0;
      bottom_q <= '0;
      x_q      <= '0;
      y_q      <= '0;
    end else if (accept) begin
      left_q   <= left_d;
      right_q  <= right_d;
      top_q    <= top_d;
      bottom_q <= bottom_d;
      x_q      <= x_d;
      y_q      <= y_d;
    end
  end

  assign cur_x = x_q;
  assign cur_y = y_q;

  assert_left_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op == OP_LEFT |=> x_q == $past(val) && left_q == $past(val));

  assert_top_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op == OP_TOP |=> y_q == $past(val) && top_q == $past(val));

  assert_col_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op == OP_PIXEL && x_q < right_q
    |=> x_q == $past(x_q) + 1'b1 && y_q == $past(y_q));

  assert_corner_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op == OP_PIXEL && x_q >= right_q && y_q >= bottom_q
    |=> x_q == $past(left_q) && y_q == $past(top_q));

endmodule

// File: rtl/pixwin_wstage.sv
module pixwin_wstage #(
  parameter int FB_WIDTH = 480,
  parameter int COORD_W  = 10,
  parameter int PIX_W    = 16,
  parameter int ADDR_W   = 19
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               issue,
  input  logic [COORD_W-1:0] x,
  input  logic [COORD_W-1:0] y,
  input  logic [PIX_W-1:0]   pix,
  output logic               we,
  output logic [ADDR_W-1:0]  addr,
  output logic [PIX_W-1:0]   wdata
);

  localparam logic [ADDR_W-1:0] WIDTH_K = ADDR_W'(FB_WIDTH);

  logic [ADDR_W-1:0] lin_d, addr_q;
  logic [PIX_W-1:0]  data_q;
  logic              we_q;

  always_comb begin
    lin_d = WIDTH_K * ADDR_W'(y) + ADDR_W'(x);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) we_q <= 1'b0;
    else        we_q <= issue;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (issue) begin
      addr_q <= lin_d;
      data_q <= pix;
    end
  end

  assign we    = we_q;
  assign addr  = addr_q;
  assign wdata = data_q;

  assert_write_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    issue |=> we_q && data_q == $past(pix)
              && addr_q == $past(WIDTH_K * ADDR_W'(y) + ADDR_W'(x)));

endmodule

// File: rtl/pixwin_writer.sv
module pixwin_writer
  import pixwin_pkg::*;
#(
  parameter int FB_WIDTH = 480,
  parameter int COORD_W  = 10,
  parameter int PIX_W    = 16,
  parameter int ADDR_W   = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_valid,
  input  logic [SEL_W-1:0]  sel_code,
  input  logic              din_valid,
  output logic              din_ready,
  input  logic [PIX_W-1:0]  din_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [PIX_W-1:0]  mem_wdata
);

  logic [SEL_W-1:0]   sel_q;
  win_op_e            op;
  logic               accept, issue;
  logic [COORD_W-1:0] cur_x, cur_y;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sel_q <= '0;
    else if (sel_valid) sel_q <= sel_code;
  end

  assign op        = decode_sel(sel_q);
  assign din_ready = !mem_we;
  assign accept    = din_valid && din_ready;
  assign issue     = accept && (op == OP_PIXEL);

  pixwin_cursor #(
    .COORD_W (COORD_W)
  ) u_cursor (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .op     (op),
    .val    (din_data[COORD_W-1:0]),
    .cur_x  (cur_x),
    .cur_y  (cur_y)
  );

  pixwin_wstage #(
    .FB_WIDTH (FB_WIDTH),
    .COORD_W  (COORD_W),
    .PIX_W    (PIX_W),
    .ADDR_W   (ADDR_W)
  ) u_wstage (
    .clk   (clk),
    .rst_n (rst_n),
    .issue (issue),
    .x     (cur_x),
    .y     (cur_y),
    .pix   (din_data),
    .we    (mem_we),
    .addr  (mem_addr),
    .wdata (mem_wdata)
  );

  assert_write_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  assert_bound_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op != OP_PIXEL |=> !mem_we);

  assert_sel_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid && accept && decode_sel(sel_q) == OP_PIXEL |=> mem_we);

endmodule

// File: tb/pixwin_writer_test.sv
module pixwin_writer_test;

  localparam int CLK_PERIOD = 10;
  localparam int FBW = 16;
  localparam int CW  = 6;
  localparam int AW  = 11;
  localparam int PW  = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          sel_valid = 1'b0;
  logic [7:0]    sel_code = '0;
  logic          din_valid = 1'b0;
  logic          din_ready;
  logic [PW-1:0] din_data = '0;
  logic          mem_we;
  logic [AW-1:0] mem_addr;
  logic [PW-1:0] mem_wdata;

  int n_run = 0;
  int n_fail = 0;
  bit running = 0;

  pixwin_writer #(.FB_WIDTH(FBW), .COORD_W(CW), .PIX_W(PW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .sel_valid(sel_valid), .sel_code(sel_code),
    .din_valid(din_valid), .din_ready(din_ready), .din_data(din_data),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_l, m_r, m_t, m_b, m_x, m_y, m_sel;
  bit e_we;
  int e_addr, e_data;
  int ref_mem [2048];
  int dut_mem [2048];
  int wr_addr [$];
  int wr_data [$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_l = 0; m_r = 0; m_t = 0; m_b = 0; m_x = 0; m_y = 0; m_sel = 0; e_we = 0;
      e_addr = 0; e_data = 0;
    end else begin
      bit nw;
      nw = 0;
      if (din_valid && !e_we) begin
        int v;
        v = din_data % (1 << CW);
        if (m_sel == 1) begin m_l = v; m_x = v; end
        else if (m_sel == 2) m_r = v;
        else if (m_sel == 3) begin m_t = v; m_y = v; end
        else if (m_sel == 4) m_b = v;
        else begin
          nw = 1;
          e_addr = (FBW * m_y + m_x) % (1 << AW);
          e_data = din_data;
          ref_mem[e_addr] = e_data;
          m_x = m_x + 1;
          if (m_x > m_r) begin
            m_x = m_l;
            m_y = m_y + 1;
            if (m_y > m_b) m_y = m_t;
          end
        end
      end
      if (sel_valid) m_sel = sel_code;
      e_we = nw;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (running && rst_n) begin
      chk(mem_we === e_we, "R6 mem_we", mem_we, e_we);
      chk(din_ready === !e_we, "R9 din_ready", din_ready, !e_we);
      if (e_we) begin
        chk(mem_addr == AW'(e_addr), "R7 mem_addr", mem_addr, e_addr);
        chk(mem_wdata == PW'(e_data), "R6 mem_wdata", mem_wdata, e_data);
      end
      if (mem_we === 1'b1) begin
        dut_mem[mem_addr] = mem_wdata;
        wr_addr.push_back(mem_addr);
        wr_data.push_back(mem_wdata);
      end
    end
  end

  task automatic set_sel(input logic [7:0] c);
    @(negedge clk);
    sel_valid = 1'b1;
    sel_code  = c;
    @(negedge clk);
    sel_valid = 1'b0;
  endtask

  task automatic send(input logic [PW-1:0] d);
    @(negedge clk);
    while (!din_ready) @(negedge clk);
    din_valid = 1'b1;
    din_data  = d;
    @(negedge clk);
    din_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    chk(0, "watchdog", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 2048; i++) begin ref_mem[i] = 0; dut_mem[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    running = 1;
    @(negedge clk);
    chk(din_ready === 1'b1, "R1 ready after reset", din_ready, 1);
    chk(mem_we === 1'b0, "R1 no write after reset", mem_we, 0);
    send(16'hAA01);
    send(16'hAA02);
    // window x 2..4, y 1..2
    set_sel(8'h01); send(16'h0002);
    set_sel(8'h02); send(16'h0004);
    set_sel(8'h03); send(16'h0001);
    set_sel(8'h04); send(16'h0002);
    set_sel(8'h2C);
    for (int i = 0; i < 8; i++) send(16'h1000 + 16'(i));
    // select change in the same cycle as a data word
    @(negedge clk);
    while (!din_ready) @(negedge clk);
    sel_valid = 1'b1; sel_code = 8'h01; din_valid = 1'b1; din_data = 16'hBEEF;
    @(negedge clk);
    sel_valid = 1'b0; din_valid = 1'b0;
    send(16'h0005);
    set_sel(8'h2C);
    send(16'h7777);
    repeat (4) @(negedge clk);

    chk(wr_addr.size() == 12, "R2 R3 R4 R5 bound writes silent", wr_addr.size(), 12);
    if (wr_addr.size() == 12) begin
      chk(wr_addr[0] == 0 && wr_addr[1] == 0, "R1 reset window at origin", wr_addr[1], 0);
      chk(wr_addr[2] == 18 && wr_data[2] == 16'h1000, "R6 R2 R4 first pixel", wr_addr[2], 18);
      chk(wr_addr[4] == 20, "R7 column step", wr_addr[4], 20);
      chk(wr_addr[5] == 34, "R7 R3 column wrap", wr_addr[5], 34);
      chk(wr_addr[7] == 36, "R5 bottom row", wr_addr[7], 36);
      chk(wr_addr[8] == 18 && wr_data[8] == 16'h1006, "R8 corner wrap", wr_addr[8], 18);
      chk(wr_addr[9] == 19, "R8 after wrap", wr_addr[9], 19);
      chk(wr_addr[10] == 20 && wr_data[10] == 16'hBEEF, "R10 old select used", wr_addr[10], 20);
      chk(wr_addr[11] == 37, "R10 new select applied", wr_addr[11], 37);
    end
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < 2048; i++) if (ref_mem[i] != dut_mem[i]) bad++;
      chk(bad == 0, "R6 memory image", bad, 0);
    end
    running = 0;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule